// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog with two thresholds on one tick counter. While it is enabled, each cycle with `tick` high advances a counter. Software keeps the system alive by writing a restart command, which sets the count back to zero. If software stops doing so, the count first reaches the warning threshold. That raises a level interrupt so a handler can try to recover. If the count then reaches the final threshold, the block sends a one-cycle reset request to the chip's reset controller and stops counting.

A sticky cause flag records that a reset request was issued. It is held on its own power-on reset. The system reset that the request triggers therefore leaves the flag alone, and boot software can read why the chip restarted. The flag is cleared only by power-on reset or by software writing 1 to it. The usual programming order is: disable, restart, write both thresholds, enable. Threshold writes are accepted at any time, including while the timer is disabled.

Top module: `wdog_two_stage`

## Requirements
- R1: Byte offsets on the bus: 0x04 restart (write-only, reads 0), 0x08 enable (bit 0), 0x0C cause flag (bit 0), 0x10 warning threshold, 0x14 final threshold. Only the low CNT_W bits (default 28) of a threshold are stored, and the bits above them read 0. Writes are accepted while the timer is disabled.
- R2: Writing a value with bit 0 set to offset 0x04 clears the count and the warning interrupt, and lets counting resume after a bite.
- R3: The count advances by one on each clock edge where `tick` is high, enable is 1 and the timer has not bitten. When enable is 0 the count holds.
- R4: On the edge after the count equals a nonzero warning threshold, `bark_irq` rises. It stays high until a restart write or until enable is cleared.
- R5: On the edge after the count equals a nonzero final threshold, `reset_req` is high for exactly one cycle. On that same edge the cause flag is set, and after it the count stops advancing.
- R6: When both thresholds are equal, `bark_irq` and `reset_req` rise on the same edge.
- R7: A threshold of zero never produces a warning or a reset request.
- R8: The count saturates at 2^CNT_W-1 and never wraps to zero.
- R9: A restart write in the cycle where a threshold match is present wins, and neither a warning nor a reset request results.
- R10: The cause flag reads at bit 0 of 0x0C. It is cleared by `por_n` or by writing 1 to bit 0, and `sys_rst_n` does not clear it. If it is set and cleared in the same cycle, the set wins.
- R11: Either reset (`por_n` or `sys_rst_n` low) clears enable, both thresholds, the count and both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; the only reset of the cause flag |
| sys_rst_n | input | 1 | System reset, asynchronous, active low |
| tick | input | 1 | Count-enable strobe, one count per high cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| bark_irq | output | 1 | Warning interrupt, level |
| reset_req | output | 1 | Reset request, one-cycle pulse |

## Verification
The hardest behaviour to reach from the ports is saturation. At the default width it would take 2^28 ticks, so the bench adds a second instance built with a 6-bit count. It runs that count past its top with both thresholds at zero. It then moves the warning threshold to a small value, which a wrapped count would hit, and then to the maximum, which only a saturated count matches. The restart-priority cases also need exact timing. The bench ticks up to a threshold and issues the restart write in the very next cycle, while the match is present but before any output has registered it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int BUS_AW = 8;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFS_KICK = 8'h04;
  localparam logic [BUS_AW-1:0] OFS_CTRL = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_STAT = 8'h0C;
  localparam logic [BUS_AW-1:0] OFS_WARN = 8'h10;
  localparam logic [BUS_AW-1:0] OFS_FIRE = 8'h14;

  typedef struct packed {
    logic kick;
    logic ctrl;
    logic stat;
    logic warn;
    logic fire;
  } wr_sel_t;

  function automatic wr_sel_t decode_wr(input logic [BUS_AW-1:0] a, input logic we);
    wr_sel_t s;
    s.kick = we && (a == OFS_KICK);
    s.ctrl = we && (a == OFS_CTRL);
    s.stat = we && (a == OFS_STAT);
    s.warn = we && (a == OFS_WARN);
    s.fire = we && (a == OFS_FIRE);
    return s;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W = 28
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              core_rst_n,
  input  logic [BUS_AW-1:0] addr,
  input  logic              we,
  input  logic [BUS_DW-1:0] wdata,
  input  logic              bite_hit,
  output logic [BUS_DW-1:0] rdata,
  output logic              kick,
  output logic              enable,
  output logic [CNT_W-1:0]  warn_thr,
  output logic [CNT_W-1:0]  fire_thr,
  output logic              cause
);
  wr_sel_t sel;
  logic    unused_wdata;

  assign sel          = decode_wr(addr, we);
  assign kick         = sel.kick && wdata[0];
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      enable   <= 1'b0;
      warn_thr <= '0;
      fire_thr <= '0;
    end else begin
      if (sel.ctrl) enable   <= wdata[0];
      if (sel.warn) warn_thr <= wdata[CNT_W-1:0];
      if (sel.fire) fire_thr <= wdata[CNT_W-1:0];
    end
  end

  // cause flag lives on power-on reset only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                      cause <= 1'b0;
    else if (bite_hit)               cause <= 1'b1;
    else if (sel.stat && wdata[0])   cause <= 1'b0;
  end

  always_comb begin
    unique case (addr)
      OFS_CTRL: rdata = BUS_DW'(enable);
      OFS_STAT: rdata = BUS_DW'(cause);
      OFS_WARN: rdata = BUS_DW'(warn_thr);
      OFS_FIRE: rdata = BUS_DW'(fire_thr);
      default:  rdata = '0;
    endcase
  end

  // R10: a bite always leaves the flag set, even against a clear write
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!por_n)
    bite_hit |=> cause);

  // R10: clear write without a bite drops the flag
  a_r10_w1c: assert property (@(posedge clk) disable iff (!por_n)
    (sel.stat && wdata[0] && !bite_hit) |=> !cause);
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic             kick,
  input  logic [CNT_W-1:0] warn_thr,
  input  logic [CNT_W-1:0] fire_thr,
  output logic             bite_hit,
  output logic             bark_irq,
  output logic             reset_req
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  function automatic logic at_thr(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] t);
    return (t != '0) && (c == t);
  endfunction

  logic [CNT_W-1:0] cnt;
  logic             halted;
  logic             bark_hit;
  logic             advance;

  assign bark_hit = enable && !kick && at_thr(cnt, warn_thr);
  assign bite_hit = enable && !kick && !halted && at_thr(cnt, fire_thr);
  assign advance  = enable && !halted && !bite_hit && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      halted    <= 1'b0;
      bark_irq  <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      reset_req <= bite_hit;
      if (kick) begin
        cnt    <= '0;
        halted <= 1'b0;
      end else begin
        if (advance)  cnt    <= sat_inc(cnt);
        if (bite_hit) halted <= 1'b1;
      end
      if (kick || !enable) bark_irq <= 1'b0;
      else if (bark_hit)   bark_irq <= 1'b1;
    end
  end

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !kick) |=> (cnt == CNT_MAX));

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((!enable || halted || !tick) && !kick) |=> $stable(cnt));

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  a_r9_restart_wins: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (!bark_irq && !reset_req && cnt == '0));

  a_r4_bark_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (bark_irq && enable && !kick) |=> bark_irq);

  a_r5_stop_after_bite: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_req && !kick) |-> halted);
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int CNT_W = 28
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              tick,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              bark_irq,
  output logic              reset_req
);
  logic             core_rst_n;
  logic             kick;
  logic             enable;
  logic             cause;
  logic             bite_hit;
  logic [CNT_W-1:0] warn_thr;
  logic [CNT_W-1:0] fire_thr;

  assign core_rst_n = por_n && sys_rst_n;

  wdog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .por_n      (por_n),
    .core_rst_n (core_rst_n),
    .addr       (bus_addr),
    .we         (bus_we),
    .wdata      (bus_wdata),
    .bite_hit   (bite_hit),
    .rdata      (bus_rdata),
    .kick       (kick),
    .enable     (enable),
    .warn_thr   (warn_thr),
    .fire_thr   (fire_thr),
    .cause      (cause)
  );

  wdog_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .tick      (tick),
    .enable    (enable),
    .kick      (kick),
    .warn_thr  (warn_thr),
    .fire_thr  (fire_thr),
    .bite_hit  (bite_hit),
    .bark_irq  (bark_irq),
    .reset_req (reset_req)
  );

  // R5: the request and the cause flag appear on the same edge
  a_r5_cause_with_req: assert property (@(posedge clk) disable iff (!core_rst_n)
    reset_req |-> cause);
endmodule

// File: tb/wdog_two_stage_test.sv
module wdog_two_stage_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        por_n = 0;
  logic        sys_rst_n = 0;
  logic        tick = 0;
  logic [7:0]  addr = 0;
  logic        we = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        bark_irq, reset_req;

  logic        s_tick = 0;
  logic [7:0]  s_addr = 0;
  logic        s_we = 0;
  logic [31:0] s_wdata = 0;
  logic [31:0] s_rdata;
  logic        s_bark, s_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  string exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_two_stage uut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick(tick),
    .bus_addr(addr), .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata),
    .bark_irq(bark_irq), .reset_req(reset_req));

  wdog_two_stage #(.CNT_W(6)) uut_sat (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick(s_tick),
    .bus_addr(s_addr), .bus_we(s_we), .bus_wdata(s_wdata), .bus_rdata(s_rdata),
    .bark_irq(s_bark), .reset_req(s_req));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string req);
    addr = a;
    #1;
    check(rdata === exp, req, rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1;
      @(negedge clk);
      tick = 0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic s_wr(input logic [7:0] a, input logic [31:0] d);
    s_addr = a; s_wdata = d; s_we = 1;
    @(negedge clk);
    s_we = 0;
  endtask

  // monitor: pops one expected request per observed pulse
  bit req_prev = 0;
  always @(negedge clk) begin
    if (por_n && sys_rst_n) begin
      if (req_prev && reset_req) check(0, "R5 pulse width", 2, 1);
      if (reset_req) begin
        if (exp_q.size() == 0) check(0, "R5/R9 unexpected reset_req", 1, 0);
        else begin
          string tag;
          tag = exp_q.pop_front();
          check(1, tag, 1, 1);
        end
      end
      if (s_req) check(0, "R7 sat instance reset_req", 1, 0);
    end
    req_prev = reset_req;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "watchdog expired", 0, 1);
    if (!done) begin
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle(2);
    por_n = 1; sys_rst_n = 1;
    @(negedge clk);

    // R11 reset state
    check(bark_irq === 0 && reset_req === 0, "R11 outputs after reset", {bark_irq, reset_req}, 0);
    rd_check(8'h08, 0, "R11 enable after reset");
    rd_check(8'h10, 0, "R11 warn thr after reset");
    rd_check(8'h0C, 0, "R10 cause after power-on");

    // R1 map and width while disabled
    wr(8'h10, 32'hFFFF_FFFF);
    rd_check(8'h10, 32'h0FFF_FFFF, "R1 warn thr width");
    wr(8'h14, 32'h0000_1234);
    rd_check(8'h14, 32'h1234, "R1 fire thr readback");
    wr(8'h04, 1);
    rd_check(8'h04, 0, "R1 restart reads zero");

    // R3 no count while disabled
    wr(8'h10, 2); wr(8'h14, 0);
    ticks(5); idle(2);
    check(bark_irq === 0, "R3 disabled holds count", bark_irq, 0);

    // R4 warning timing and stickiness
    wr(8'h08, 1);
    rd_check(8'h08, 1, "R1 enable readback");
    wr(8'h04, 1);
    ticks(1); idle(2);
    check(bark_irq === 0, "R3 one tick below warn", bark_irq, 0);
    ticks(1);
    check(bark_irq === 0, "R4 not before edge", bark_irq, 0);
    idle(1);
    check(bark_irq === 1, "R4 warn raised", bark_irq, 1);
    ticks(4); idle(3);
    check(bark_irq === 1, "R4 warn sticky", bark_irq, 1);
    wr(8'h04, 1);
    check(bark_irq === 0, "R2 restart clears warn", bark_irq, 0);

    // R4 disable clears warning
    ticks(2); idle(1);
    check(bark_irq === 1, "R4 warn again", bark_irq, 1);
    wr(8'h08, 0); idle(1);
    check(bark_irq === 0, "R4 disable clears warn", bark_irq, 0);

    // R2 regular restarts keep it quiet
    wr(8'h10, 4); wr(8'h14, 6); wr(8'h08, 1); wr(8'h04, 1);
    for (int i = 0; i < 5; i++) begin ticks(3); wr(8'h04, 1); end
    idle(2);
    check(bark_irq === 0, "R2 pinged no warn", bark_irq, 0);

    // R9 restart in the match cycle
    wr(8'h10, 3); wr(8'h14, 10); wr(8'h04, 1);
    ticks(3); wr(8'h04, 1); idle(2);
    check(bark_irq === 0, "R9 restart beats warn", bark_irq, 0);
    wr(8'h10, 0); wr(8'h14, 3); wr(8'h04, 1);
    ticks(3); wr(8'h04, 1); idle(2);
    rd_check(8'h0C, 0, "R9 restart beats bite");

    // R5 bite
    wr(8'h10, 2); wr(8'h14, 4); wr(8'h04, 1);
    ticks(3);
    exp_q.push_back("R5 bite pulse");
    ticks(1);
    check(reset_req === 0, "R5 not before edge", reset_req, 0);
    idle(1);
    check(reset_req === 1, "R5 request raised", reset_req, 1);
    rd_check(8'h0C, 1, "R5 cause set");
    ticks(8); idle(2);
    check(exp_q.size() == 0, "R5 single bite", exp_q.size(), 0);

    // R10 cause survives system reset, R11 clears enable
    sys_rst_n = 0; @(negedge clk); sys_rst_n = 1; @(negedge clk);
    rd_check(8'h0C, 1, "R10 cause survives sys reset");
    rd_check(8'h08, 0, "R11 enable cleared by sys reset");
    rd_check(8'h14, 0, "R11 fire thr cleared by sys reset");
    wr(8'h0C, 1);
    rd_check(8'h0C, 0, "R10 write-one clears cause");

    // R6 equal thresholds
    wr(8'h10, 3); wr(8'h14, 3); wr(8'h08, 1); wr(8'h04, 1);
    exp_q.push_back("R6 equal bite pulse");
    ticks(3); idle(1);
    check(bark_irq === 1 && reset_req === 1, "R6 same edge", {bark_irq, reset_req}, 2'b11);
    idle(1);
    por_n = 0; @(negedge clk); por_n = 1; @(negedge clk);
    rd_check(8'h0C, 0, "R10 power-on clears cause");

    // R7 zero thresholds
    wr(8'h08, 1); wr(8'h04, 1);
    ticks(20); idle(2);
    check(bark_irq === 0, "R7 zero warn silent", bark_irq, 0);
    rd_check(8'h0C, 0, "R7 zero fire silent");

    // R8 saturation on the narrow instance
    s_wr(8'h08, 1); s_wr(8'h04, 1);
    for (int i = 0; i < 70; i++) begin s_tick = 1; @(negedge clk); s_tick = 0; end
    s_wr(8'h10, 6); idle(2);
    check(s_bark === 0, "R8 no wrap past max", s_bark, 0);
    s_wr(8'h10, 63); idle(1);
    check(s_bark === 1, "R8 held at max", s_bark, 1);

    idle(3);
    check(exp_q.size() == 0, "R5 all expected pulses seen", exp_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule